// File: doc/BRIEF.md
# Software-Refilled Translation Cache With Pinned Entries

This block is a small, fully associative cache of virtual-page-to-frame mappings. It sits on the processor's memory access path. Each access presents a virtual page number, an access kind and the current process tag. In the same cycle the block returns either a frame number, a protection fault, or a miss.

The block never walks page tables. A miss moves a two-state trap controller from `TRAP_IDLE` to `TRAP_PEND`. That raises a trap line and captures the faulting page number. System software then writes the mapping through a fill port, and the accepted fill returns the controller to `TRAP_IDLE`. A fill can name a slot outright, or it can leave slot choice to a round-robin pointer that steps over pinned slots. Pinned entries survive both that replacement and the context-switch flush, so time-critical code keeps its mappings.

The controller has two transitions:
- `TRAP_IDLE -> TRAP_PEND` on a lookup miss.
- `TRAP_PEND -> TRAP_IDLE` on any accepted fill.

In every other case it stays where it is.

Top module: `swtlb_top`

## Requirements
- R1: A lookup hits when an entry is valid, its page number equals `lk_vpn`, and either its process tag equals `lk_pid` or its global bit is set. When the access kind is also permitted, `lk_hit` is high and `lk_frame` carries the entry's frame in the same cycle. Otherwise `lk_frame` is zero.
- R2: Access kinds are encoded 0 = read, 1 = write, 2 = execute and 3 = never permitted. The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. A matching entry whose bit for the access kind is clear drives `lk_prot_fault` high and `lk_hit` low.
- R3: A lookup that matches no entry while the controller is in `TRAP_IDLE` raises `miss_trap` from the next cycle on, and latches `lk_vpn` into `miss_vpn`. Both hold until an accepted fill. Further misses in `TRAP_PEND` leave `miss_vpn` unchanged.
- R4: An entry without the global bit does not match a lookup whose process tag differs from the entry's tag.
- R5: A fill with `wr_use_idx` high writes slot `wr_idx`, even if that slot is pinned.
- R6: A fill with `wr_use_idx` low writes the first unpinned slot at or after the replacement pointer, wrapping around. The pointer then moves to that slot plus one. The pointer is 0 after reset.
- R7: If every slot is pinned, a fill with `wr_use_idx` low changes no entry. It also pulses `wr_reject` high for the cycle after the fill.
- R8: `flush` invalidates every unpinned entry at the clock edge and leaves pinned entries usable.
- R9: After reset no entry is valid, and `miss_trap` and `wr_reject` are low.
- R10: With `lk_valid` low, `lk_hit` and `lk_prot_fault` are low and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_pid | input | 8 | Current process tag |
| lk_hit | output | 1 | Permitted translation found |
| lk_frame | output | 20 | Translated frame number, zero when no hit |
| lk_prot_fault | output | 1 | Match found but access kind not permitted |
| miss_trap | output | 1 | Miss awaiting a software fill |
| miss_vpn | output | 20 | Page number of the pending miss |
| wr_en | input | 1 | Fill request |
| wr_use_idx | input | 1 | Fill goes to `wr_idx` rather than the replacement pointer |
| wr_idx | input | 4 | Explicit fill slot |
| wr_vpn | input | 20 | Fill page number |
| wr_frame | input | 20 | Fill frame number |
| wr_pid | input | 8 | Fill process tag |
| wr_perm | input | 3 | Fill permissions: bit 0 read, bit 1 write, bit 2 execute |
| wr_global | input | 1 | Fill matches any process tag |
| wr_lock | input | 1 | Fill is pinned against replacement and flush |
| wr_reject | output | 1 | Pulse: a pointer-chosen fill found no unpinned slot |
| flush | input | 1 | Invalidate all unpinned entries |

## Verification
The assertions take two things for granted. First, software never installs two live entries that can match the same page and process tag. Second, `lk_acc` is held stable while `lk_valid` is high within a cycle. The stimulus keeps to these limits. Every test starts from reset, gives each installed mapping a distinct page number, and changes lookup inputs only on the falling clock edge. Lookups that are only meant to be observed drop `lk_valid` before the next rising edge, so that a trap is raised only where a scenario intends one.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int PID_W = 8;
    localparam int N_ENT = 16;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int PERM_W = 3;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_e;

    typedef enum logic {
        TRAP_IDLE = 1'b0,
        TRAP_PEND = 1'b1
    } trap_st_e;

    typedef struct packed {
        logic              valid;
        logic              lock;
        logic              glob;
        logic [PERM_W-1:0] perm;
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_ent_t;
endpackage

// File: rtl/swtlb_match.sv
module swtlb_match
    import swtlb_pkg::*;
(
    input  tlb_ent_t [N_ENT-1:0] ents,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [PID_W-1:0]     pid,
    output logic                 found,
    output tlb_ent_t             sel
);
    logic [N_ENT-1:0] hitv;

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_cmp
            assign hitv[g] = ents[g].valid && (ents[g].vpn == vpn) &&
                             (ents[g].glob || (ents[g].pid == pid));
        end
    endgenerate

    // lowest matching slot wins; software keeps matches unique
    always_comb begin
        found = |hitv;
        sel   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hitv[i]) sel = ents[i];
        end
    end
endmodule

// File: rtl/swtlb_victim.sv
module swtlb_victim
    import swtlb_pkg::*;
(
    input  logic [N_ENT-1:0] pinned,
    input  logic [IDX_W-1:0] ptr,
    output logic             any_free,
    output logic [IDX_W-1:0] victim
);
    always_comb begin
        any_free = ~&pinned;
        victim   = ptr;
        // scan backwards so the nearest free slot from ptr is kept
        for (int k = N_ENT - 1; k >= 0; k--) begin
            if (!pinned[(int'(ptr) + k) % N_ENT])
                victim = IDX_W'((int'(ptr) + k) % N_ENT);
        end
    end
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
    import swtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_acc,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_frame,
    output logic              lk_prot_fault,
    output logic              miss_trap,
    output logic [VPN_W-1:0]  miss_vpn,
    input  logic              wr_en,
    input  logic              wr_use_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_frame,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_global,
    input  logic              wr_lock,
    output logic              wr_reject,
    input  logic              flush
);
    tlb_ent_t [N_ENT-1:0] ent_q;
    logic [IDX_W-1:0]     rr_q;
    logic [VPN_W-1:0]     miss_vpn_q;
    logic                 rej_q;
    trap_st_e             st_q, st_d;

    logic                 found, allowed, miss;
    tlb_ent_t             sel;
    logic [N_ENT-1:0]     pinned;
    logic                 any_free;
    logic [IDX_W-1:0]     vic_idx, fill_idx;
    logic                 fill_ok, fill_rr;
    tlb_ent_t             new_ent;

    swtlb_match u_match (
        .ents  (ent_q),
        .vpn   (lk_vpn),
        .pid   (lk_pid),
        .found (found),
        .sel   (sel)
    );

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_pin
            assign pinned[g] = ent_q[g].lock;
        end
    endgenerate

    swtlb_victim u_victim (
        .pinned   (pinned),
        .ptr      (rr_q),
        .any_free (any_free),
        .victim   (vic_idx)
    );

    // lookup path
    always_comb begin
        unique case (acc_e'(lk_acc))
            ACC_RD:  allowed = sel.perm[0];
            ACC_WR:  allowed = sel.perm[1];
            ACC_EX:  allowed = sel.perm[2];
            ACC_BAD: allowed = 1'b0;
        endcase
    end

    assign lk_hit        = lk_valid && found && allowed;
    assign lk_prot_fault = lk_valid && found && !allowed;
    assign lk_frame      = lk_hit ? sel.pfn : '0;
    assign miss          = lk_valid && !found;

    // fill path
    assign fill_rr  = wr_en && !wr_use_idx;
    assign fill_ok  = wr_en && (wr_use_idx || any_free);
    assign fill_idx = wr_use_idx ? wr_idx : vic_idx;

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.lock  = wr_lock;
        new_ent.glob  = wr_global;
        new_ent.perm  = wr_perm;
        new_ent.pid   = wr_pid;
        new_ent.vpn   = wr_vpn;
        new_ent.pfn   = wr_frame;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (fill_ok && (int'(fill_idx) == i))
                    ent_q[i] <= new_ent;
                else if (flush && !ent_q[i].lock)
                    ent_q[i].valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q  <= '0;
            rej_q <= 1'b0;
        end else begin
            rej_q <= fill_rr && !any_free;
            if (fill_rr && any_free) rr_q <= vic_idx + 1'b1;
        end
    end

    // trap controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= TRAP_IDLE;
            miss_vpn_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == TRAP_IDLE && miss) miss_vpn_q <= lk_vpn;
        end
    end

    // trap controller: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TRAP_IDLE: if (miss)    st_d = TRAP_PEND;
            TRAP_PEND: if (fill_ok) st_d = TRAP_IDLE;
        endcase
    end

    // trap controller: outputs
    always_comb begin
        miss_trap = (st_q == TRAP_PEND);
        miss_vpn  = miss_vpn_q;
        wr_reject = rej_q;
    end
endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk
    import swtlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_prot_fault,
    input logic             miss_trap,
    input logic [VPN_W-1:0] miss_vpn,
    input logic             wr_en,
    input logic             wr_use_idx,
    input logic             wr_reject
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_prot_fault));

    // R2
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_prot_fault));

    // R3
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_trap) |-> $past(lk_valid && !lk_hit && !lk_prot_fault));

    // R3
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_trap && $past(miss_trap)) |-> $stable(miss_vpn));

    // R7
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en && !wr_use_idx));
endmodule

bind swtlb_top swtlb_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .lk_prot_fault (lk_prot_fault),
    .miss_trap     (miss_trap),
    .miss_vpn      (miss_vpn),
    .wr_en         (wr_en),
    .wr_use_idx    (wr_use_idx),
    .wr_reject     (wr_reject)
);

// File: tb/swtlb_top_bench.sv
`timescale 1ns/100ps
module swtlb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [19:0] lk_vpn;
    logic [1:0]  lk_acc;
    logic [7:0]  lk_pid;
    logic        lk_hit;
    logic [19:0] lk_frame;
    logic        lk_prot_fault;
    logic        miss_trap;
    logic [19:0] miss_vpn;
    logic        wr_en, wr_use_idx;
    logic [3:0]  wr_idx;
    logic [19:0] wr_vpn, wr_frame;
    logic [7:0]  wr_pid;
    logic [2:0]  wr_perm;
    logic        wr_global, wr_lock;
    logic        wr_reject;
    logic        flush;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    swtlb_top u_swtlb_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lk_valid = 0; lk_vpn = 0; lk_acc = 0; lk_pid = 0;
        wr_en = 0; wr_use_idx = 0; wr_idx = 0; wr_vpn = 0; wr_frame = 0;
        wr_pid = 0; wr_perm = 0; wr_global = 0; wr_lock = 0; flush = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input logic use_idx, input logic [3:0] idx, input logic [19:0] vpn,
                        input logic [19:0] pfn, input logic [7:0] pid, input logic [2:0] perm,
                        input logic glob, input logic lock);
        @(negedge clk);
        wr_en = 1; wr_use_idx = use_idx; wr_idx = idx; wr_vpn = vpn; wr_frame = pfn;
        wr_pid = pid; wr_perm = perm; wr_global = glob; wr_lock = lock;
        @(negedge clk);
        wr_en = 0;
    endtask

    // observe-only lookup; lk_valid dropped before the next rising edge
    task automatic look(input string req, input logic [19:0] vpn, input logic [7:0] pid,
                        input logic [1:0] acc, input logic eh, input logic ef, input logic [19:0] efr);
        @(negedge clk);
        lk_valid = 1; lk_vpn = vpn; lk_pid = pid; lk_acc = acc;
        #1;
        chk({req, " hit"}, 32'(lk_hit), 32'(eh));
        chk({req, " fault"}, 32'(lk_prot_fault), 32'(ef));
        chk({req, " frame"}, 32'(lk_frame), 32'(efr));
        lk_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R9 trap", 32'(miss_trap), 0);
        chk("R9 reject", 32'(wr_reject), 0);
        look("R9 empty", 20'h00000, 8'h00, 2'd0, 0, 0, 0);
    endtask

    task automatic t_hit_perm();
        do_reset();
        fill(1, 4'd3, 20'h12345, 20'hABCDE, 8'h05, 3'b001, 0, 0);
        look("R1 read", 20'h12345, 8'h05, 2'd0, 1, 0, 20'hABCDE);
        look("R2 write", 20'h12345, 8'h05, 2'd1, 0, 1, 0);
        look("R2 exec", 20'h12345, 8'h05, 2'd2, 0, 1, 0);
        look("R2 code3", 20'h12345, 8'h05, 2'd3, 0, 1, 0);
        look("R4 pid", 20'h12345, 8'h06, 2'd0, 0, 0, 0);
        fill(1, 4'd4, 20'h00777, 20'h0F0F0, 8'h01, 3'b100, 1, 0);
        look("R1 global", 20'h00777, 8'h09, 2'd2, 1, 0, 20'h0F0F0);
    endtask

    task automatic t_idle();
        do_reset();
        fill(1, 4'd0, 20'h00042, 20'h00099, 8'h00, 3'b111, 0, 0);
        @(negedge clk);
        lk_valid = 0; lk_vpn = 20'h00042; lk_pid = 0; lk_acc = 0;
        #1;
        chk("R10 hit", 32'(lk_hit), 0);
        chk("R10 fault", 32'(lk_prot_fault), 0);
        lk_vpn = 20'h0DEAD;
        @(negedge clk);
        chk("R10 trap", 32'(miss_trap), 0);
    endtask

    task automatic t_trap();
        do_reset();
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h55555; lk_pid = 8'h05; lk_acc = 0;
        @(negedge clk);
        lk_vpn = 20'h66666;
        chk("R3 trap up", 32'(miss_trap), 1);
        chk("R3 vpn", 32'(miss_vpn), 32'h55555);
        @(negedge clk);
        lk_valid = 0;
        chk("R3 vpn held", 32'(miss_vpn), 32'h55555);
        fill(0, 4'd0, 20'h55555, 20'h11111, 8'h05, 3'b001, 0, 0);
        chk("R3 trap cleared", 32'(miss_trap), 0);
        look("R3 refilled", 20'h55555, 8'h05, 2'd0, 1, 0, 20'h11111);
    endtask

    task automatic t_round_robin();
        do_reset();
        fill(1, 4'd1, 20'h00101, 20'h00001, 8'h00, 3'b001, 0, 1);
        fill(1, 4'd2, 20'h00102, 20'h00002, 8'h00, 3'b001, 0, 1);
        fill(0, 4'd0, 20'h00200, 20'h00020, 8'h00, 3'b001, 0, 0);
        fill(0, 4'd0, 20'h00300, 20'h00030, 8'h00, 3'b001, 0, 0);
        look("R6 second victim", 20'h00300, 8'h00, 2'd0, 1, 0, 20'h00030);
        fill(1, 4'd3, 20'h00999, 20'h00099, 8'h00, 3'b001, 0, 0);
        look("R6 skip pinned to slot 3", 20'h00300, 8'h00, 2'd0, 0, 0, 0);
        look("R6 first victim slot 0", 20'h00200, 8'h00, 2'd0, 1, 0, 20'h00020);
        look("R6 pinned kept", 20'h00101, 8'h00, 2'd0, 1, 0, 20'h00001);
        fill(1, 4'd1, 20'h00777, 20'h00077, 8'h00, 3'b001, 0, 0);
        look("R5 pinned overwritten", 20'h00101, 8'h00, 2'd0, 0, 0, 0);
        look("R5 new entry", 20'h00777, 8'h00, 2'd0, 1, 0, 20'h00077);
    endtask

    task automatic t_all_pinned();
        do_reset();
        for (int i = 0; i < 16; i++)
            fill(1, 4'(i), 20'h01000 + 20'(i), 20'h02000 + 20'(i), 8'h00, 3'b001, 0, 1);
        @(negedge clk);
        wr_en = 1; wr_use_idx = 0; wr_vpn = 20'h03000; wr_frame = 20'h04000; wr_lock = 0;
        @(negedge clk);
        wr_en = 0;
        chk("R7 reject pulse", 32'(wr_reject), 1);
        @(negedge clk);
        chk("R7 reject drops", 32'(wr_reject), 0);
        look("R7 not written", 20'h03000, 8'h00, 2'd0, 0, 0, 0);
        look("R7 slot0 intact", 20'h01000, 8'h00, 2'd0, 1, 0, 20'h02000);
        look("R7 slot15 intact", 20'h0100F, 8'h00, 2'd0, 1, 0, 20'h0200F);
    endtask

    task automatic t_flush();
        do_reset();
        fill(1, 4'd0, 20'h0AAAA, 20'h0000A, 8'h03, 3'b011, 0, 1);
        fill(1, 4'd1, 20'h0BBBB, 20'h0000B, 8'h03, 3'b011, 0, 0);
        @(negedge clk);
        flush = 1;
        @(negedge clk);
        flush = 0;
        look("R8 pinned survives", 20'h0AAAA, 8'h03, 2'd1, 1, 0, 20'h0000A);
        look("R8 unpinned gone", 20'h0BBBB, 8'h03, 2'd0, 0, 0, 0);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_hit_perm();
        t_idle();
        t_trap();
        t_round_robin();
        t_all_pinned();
        t_flush();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule